// File: doc/BRIEF.md
# Receive CRC Engine with Deferred Preset and Late Character Exclusion

This block keeps the running 16-bit CRC of a synchronous serial receiver. It takes one byte per character strobe and folds it into the register least significant bit first. A polynomial select picks one of two CRC kinds. A CRC-good flag reports when the register holds the value left after a frame and its check bytes.

Two control pulses steer the engine. The preset request does not touch the register when it is issued. It arms a preset that is loaded as the base of the next character fold. The exclusion request removes the character most recently received from the CRC, as if that character had never arrived. It is honoured only in byte-synchronous mode, and only until eight bit-cycle ticks have been counted after that character. To make this possible, the engine keeps a copy of the register as it stood before the last fold. An accepted exclusion puts that copy back.

Top module: `rx_crc_excl`

## Requirements
- R1: After reset, `crc_value` is 0x0000, `crc_good` is 1, a preset is armed, and no exclusion window is open.
- R2: With `poly_sel`=0 (CRC-16, reflected polynomial 0xA001, preset 0x0000), each character is folded bit 0 first on the cycle after `chr_valid`. Starting from the preset, the ASCII bytes "123456789" give 0xBB3D.
- R3: With `poly_sel`=1 (CCITT, reflected polynomial 0x8408, preset 0xFFFF, no final inversion), the same nine bytes give 0x6F91 from the preset.
- R4: A `cmd_init` pulse with no character leaves `crc_value` unchanged. The next character, or a character strobed in the same cycle as `cmd_init`, is folded from the preset of the current `poly_sel` instead of the register.
- R5: With `byte_sync_mode`=1, a `cmd_excl` pulse is accepted if it arrives after a character and before the 8th `bit_tick` following it. On the next cycle it restores `crc_value` to the base that character was folded from. Clock cycles without a tick do not shorten the window.
- R6: A `cmd_excl` pulse that arrives once 8 `bit_tick`s have followed the last character leaves `crc_value` unchanged.
- R7: With `byte_sync_mode`=0, `cmd_excl` has no effect on `crc_value`.
- R8: If an accepted `cmd_excl` and a new `chr_valid` fall in the same cycle, the new character is folded onto the restored value. The new character then opens a fresh window.
- R9: `crc_good` is 1 exactly when `crc_value` is 0x0000. This is the state after a frame is followed by its CRC register value, sent low byte then high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | 8 | Received character |
| bit_tick | input | 1 | One pulse per receive bit cycle |
| poly_sel | input | 1 | 0 = CRC-16 with zero preset, 1 = CCITT with all-ones preset |
| byte_sync_mode | input | 1 | 1 when the receiver runs in byte-synchronous mode |
| cmd_init | input | 1 | Arm a preset for the next character |
| cmd_excl | input | 1 | Remove the last character from the CRC |
| crc_value | output | 16 | Current CRC register |
| crc_good | output | 1 | CRC register equals the good residue 0x0000 |

## Verification
The exclusion of the previous character and the fold of a new one can land in the same clock. A preset request can coincide with a character strobe in the same way. The bench forces both collisions. It strobes a second character in the very cycle the exclusion is issued, and a preset request together with the first character of a frame. In each case it compares the register one cycle later against a value computed by its own bit-serial fold, starting from the restored or preset base. The window edge is probed on both sides, with seven and with eight ticks between the character and the request.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;

    localparam int CRC_W  = 16;
    localparam int CHAR_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [CHAR_W-1:0] chr_t;

    typedef enum logic {
        KIND_CRC16 = 1'b0,
        KIND_CCITT = 1'b1
    } crc_kind_e;

    typedef struct packed {
        crc_t run;    // live CRC register
        crc_t prior;  // base used for the most recent fold
        logic armed;  // preset pending for next character
    } crc_state_t;

    function automatic crc_t poly_rev(crc_kind_e k);
        return (k == KIND_CCITT) ? crc_t'(16'h8408) : crc_t'(16'hA001);
    endfunction

    function automatic crc_t preset_of(crc_kind_e k);
        return (k == KIND_CCITT) ? crc_t'(16'hFFFF) : crc_t'(16'h0000);
    endfunction

endpackage

// File: rtl/crc_fold.sv
module crc_fold
    import rxcrc_pkg::*;
#(
    parameter int DW = CHAR_W
) (
    input  crc_t        base,
    input  logic [DW-1:0] data,
    input  crc_kind_e   kind,
    output crc_t        folded
);
    crc_t stage [DW+1];
    crc_t poly;

    assign poly     = poly_rev(kind);
    assign stage[0] = base;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic fb;
        assign fb         = stage[i][0] ^ data[i];
        assign stage[i+1] = (stage[i] >> 1) ^ (fb ? poly : '0);
    end

    assign folded = stage[DW];
endmodule

// File: rtl/excl_window.sv
module excl_window #(
    parameter int WINDOW_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic chr_valid,
    input  logic bit_tick,
    input  logic take,
    output logic open
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_TICKS);

    logic [CW-1:0] ticks;
    logic          live;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks <= '0;
            live  <= 1'b0;
        end else if (chr_valid) begin
            ticks <= '0;
            live  <= 1'b1;
        end else begin
            if (take)
                live <= 1'b0;
            if (bit_tick && ticks < LIMIT)
                ticks <= ticks + 1'b1;
        end
    end

    assign open = live && (ticks < LIMIT);
endmodule

// File: rtl/rx_crc_excl.sv
module rx_crc_excl
    import rxcrc_pkg::*;
#(
    parameter int WINDOW_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chr_valid,
    input  logic [7:0]  chr_data,
    input  logic        bit_tick,
    input  logic        poly_sel,
    input  logic        byte_sync_mode,
    input  logic        cmd_init,
    input  logic        cmd_excl,
    output logic [15:0] crc_value,
    output logic        crc_good
);
    crc_state_t st, st_nx;
    crc_kind_e  kind;
    crc_t       base, folded;
    logic       win_open, excl_ok;

    assign kind    = crc_kind_e'(poly_sel);
    assign excl_ok = cmd_excl && byte_sync_mode && win_open;

    excl_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
        .clk       (clk),
        .rst       (rst),
        .chr_valid (chr_valid),
        .bit_tick  (bit_tick),
        .take      (excl_ok),
        .open      (win_open)
    );

    always_comb begin
        if (st.armed || cmd_init)
            base = preset_of(kind);
        else if (excl_ok)
            base = st.prior;
        else
            base = st.run;
    end

    crc_fold #(.DW(CHAR_W)) u_fold (
        .base   (base),
        .data   (chr_data),
        .kind   (kind),
        .folded (folded)
    );

    always_comb begin
        st_nx = st;
        if (chr_valid) begin
            st_nx.prior = base;
            st_nx.run   = folded;
            st_nx.armed = 1'b0;
        end else begin
            if (excl_ok)
                st_nx.run = st.prior;
            if (cmd_init)
                st_nx.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.run   <= '0;
            st.prior <= '0;
            st.armed <= 1'b1;
        end else begin
            st <= st_nx;
        end
    end

    assign crc_value = st.run;
    assign crc_good  = (st.run == '0);
endmodule

// File: rtl/rx_crc_excl_chk.sv
module rx_crc_excl_chk #(
    parameter int WINDOW_TICKS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        chr_valid,
    input logic        bit_tick,
    input logic        poly_sel,
    input logic        byte_sync_mode,
    input logic        cmd_init,
    input logic        cmd_excl,
    input logic [15:0] crc_value
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_TICKS);

    logic [CW-1:0] n_ticks;
    logic          seen, used, pend;
    logic [15:0]   pre;
    logic          acc;

    assign acc = cmd_excl && byte_sync_mode && seen && !used && (n_ticks < LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_ticks <= '0;
            seen    <= 1'b0;
            used    <= 1'b0;
            pend    <= 1'b1;
            pre     <= '0;
        end else if (chr_valid) begin
            n_ticks <= '0;
            seen    <= 1'b1;
            used    <= 1'b0;
            pend    <= 1'b0;
            pre     <= (pend || cmd_init) ? (poly_sel ? 16'hFFFF : 16'h0000)
                                          : (acc ? pre : crc_value);
        end else begin
            if (acc)
                used <= 1'b1;
            if (cmd_init)
                pend <= 1'b1;
            if (bit_tick && n_ticks < LIMIT)
                n_ticks <= n_ticks + 1'b1;
        end
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!chr_valid && !cmd_excl) |=> $stable(crc_value)); // R4

    AST_EXCL_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (acc && !chr_valid) |=> (crc_value == $past(pre))); // R5

    AST_LATE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!chr_valid && cmd_excl && n_ticks >= LIMIT) |=> $stable(crc_value)); // R6

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
        (!chr_valid && cmd_excl && !byte_sync_mode) |=> $stable(crc_value)); // R7
endmodule

bind rx_crc_excl rx_crc_excl_chk #(.WINDOW_TICKS(WINDOW_TICKS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .chr_valid      (chr_valid),
    .bit_tick       (bit_tick),
    .poly_sel       (poly_sel),
    .byte_sync_mode (byte_sync_mode),
    .cmd_init       (cmd_init),
    .cmd_excl       (cmd_excl),
    .crc_value      (crc_value)
);

// File: tb/tb_rx_crc_excl.sv
`timescale 1ns/1ps
module tb_rx_crc_excl;
    logic        clk = 0;
    logic        rst = 1;
    logic        chr_valid = 0;
    logic [7:0]  chr_data = 0;
    logic        bit_tick = 0;
    logic        poly_sel = 0;
    logic        byte_sync_mode = 1;
    logic        cmd_init = 0;
    logic        cmd_excl = 0;
    logic [15:0] crc_value;
    logic        crc_good;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    rx_crc_excl dut (
        .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
        .bit_tick(bit_tick), .poly_sel(poly_sel), .byte_sync_mode(byte_sync_mode),
        .cmd_init(cmd_init), .cmd_excl(cmd_excl),
        .crc_value(crc_value), .crc_good(crc_good)
    );

    // behavioural reference
    int m_crc, m_snap, m_ticks;
    bit m_armed, m_seen, m_used;

    function automatic int ref_fold(int c, int d, bit ccitt);
        int r = c;
        for (int i = 0; i < 8; i++) begin
            bit fb = r[0] ^ d[i];
            r = r >>> 1;
            if (fb) r = r ^ (ccitt ? 32'h8408 : 32'hA001);
        end
        return r & 32'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_crc = 0; m_snap = 0; m_ticks = 0;
            m_armed = 1; m_seen = 0; m_used = 0;
        end else begin
            bit acc;
            int b;
            acc = cmd_excl && byte_sync_mode && m_seen && !m_used && m_ticks < 8;
            if (chr_valid) begin
                if (m_armed || cmd_init) b = poly_sel ? 32'hFFFF : 0;
                else if (acc)            b = m_snap;
                else                     b = m_crc;
                m_snap  = b;
                m_crc   = ref_fold(b, chr_data, poly_sel);
                m_armed = 0; m_seen = 1; m_ticks = 0; m_used = 0;
            end else begin
                if (acc) begin m_crc = m_snap; m_used = 1; end
                if (cmd_init) m_armed = 1;
                if (bit_tick && m_ticks < 8) m_ticks++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (crc_value !== m_crc[15:0] || crc_good !== (m_crc == 0)) begin
                n_fail++;
                $display("FAIL %s model: crc_value=%h good=%b expected %h good=%b",
                         cur_req, crc_value, crc_good, m_crc[15:0], (m_crc == 0));
            end
        end
    end

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(bit cv, byte d, bit tk, bit ci, bit ce);
        @(posedge clk); #1;
        chr_valid = cv; chr_data = d; bit_tick = tk; cmd_init = ci; cmd_excl = ce;
    endtask

    task automatic settle();
        drive(0, 0, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 1, 0, 0);
    endtask

    task automatic send_check_string(bit ccitt_init_same_cycle);
        string s = "123456789";
        for (int i = 0; i < 9; i++)
            drive(1, s[i], 0, (i == 0) && ccitt_init_same_cycle, 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v0, v1, cv;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 reset value", crc_value, 16'h0000);
        chk("R1 reset good", {15'd0, crc_good}, 16'h0001);

        // R2: CRC-16 check string from the reset-armed preset
        cur_req = "R2";
        poly_sel = 0;
        send_check_string(0);
        settle();
        chk("R2 crc16 check", crc_value, 16'hBB3D);

        // R9: append register low then high byte
        cur_req = "R9";
        cv = crc_value;
        drive(1, cv[7:0], 0, 0, 0);
        drive(1, cv[15:8], 0, 0, 0);
        settle();
        chk("R9 residue zero", crc_value, 16'h0000);
        chk("R9 good flag", {15'd0, crc_good}, 16'h0001);

        // R4: init alone does not change the register
        cur_req = "R4";
        drive(1, 8'h5A, 0, 0, 0);
        settle();
        v0 = crc_value;
        drive(0, 0, 0, 1, 0);
        settle();
        chk("R4 init deferred", crc_value, v0);
        drive(1, 8'h31, 0, 0, 0);
        settle();
        chk("R4 init applied on next char", crc_value, 16'(ref_fold(0, 8'h31, 0)));

        // R3 with init in the same cycle as the first char (R4 coincidence)
        cur_req = "R3";
        poly_sel = 1;
        send_check_string(1);
        settle();
        chk("R3 ccitt check (R4 same-cycle init)", crc_value, 16'h6F91);

        // R5: exclusion after 7 ticks and idle cycles without ticks
        cur_req = "R5";
        byte_sync_mode = 1;
        v0 = crc_value;
        drive(1, 8'hA5, 0, 0, 0);
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 0);
        ticks(7);
        drive(0, 0, 0, 0, 1);
        settle();
        chk("R5 restore at 7 ticks", crc_value, v0);

        // R6: exclusion after 8 ticks ignored
        cur_req = "R6";
        drive(1, 8'h3C, 0, 0, 0);
        settle();
        v1 = crc_value;
        ticks(8);
        drive(0, 0, 0, 0, 1);
        settle();
        chk("R6 late exclusion ignored", crc_value, v1);

        // R7: wrong mode ignored
        cur_req = "R7";
        byte_sync_mode = 0;
        drive(1, 8'hC3, 0, 0, 0);
        settle();
        v1 = crc_value;
        drive(0, 0, 0, 0, 1);
        settle();
        chk("R7 mode gate", crc_value, v1);
        byte_sync_mode = 1;

        // R8: exclusion coincides with next char
        cur_req = "R8";
        v0 = crc_value;
        drive(1, 8'h11, 0, 0, 0);
        drive(1, 8'h22, 1, 0, 1);
        settle();
        chk("R8 fold on restored", crc_value, 16'(ref_fold(v0, 8'h22, 1)));
        drive(0, 0, 0, 0, 1);
        settle();
        chk("R8 fresh window", crc_value, v0);

        // mixed traffic, compared against the model every clock
        cur_req = "R2/R3/R5 mixed";
        for (int i = 0; i < 400; i++) begin
            int sel = (i * 7 + 3) % 11;
            poly_sel = (i / 50) % 2;
            drive(sel < 4, byte'(i * 37 + 5), sel >= 3, sel == 9, sel == 6 || sel == 3);
        end
        settle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule